// File: doc/BRIEF.md
# Two-Bank SDRAM Command Front End

This block is the command stage of a behavioural two-bank synchronous DRAM model. On each rising clock edge it looks at the clock-enable, chip-select and the three command strobes together with a 12-bit address bus and two byte-mask bits. It turns them into one decoded command strobe: activate, read, write, precharge, auto refresh, mode set or burst stop. It also reports the bank, row, column, auto-precharge flag and byte enables that belong to that command.

Per bank it keeps an open/idle flag and the row that is open. Commands that do not fit the bank state raise a one-cycle error flag and are otherwise dropped: an activate to a bank that already has an open row, or a read or write to an idle bank. A read or write that asks for auto-precharge closes its bank once a burst of the programmed length has run its course. The burst length comes from the low bits of the captured mode word. The array, the data path and analog timing sit elsewhere.

Top module: `sdram_cmd_front`

## Requirements
- R1: The pin levels {cs_n, ras_n, cas_n, we_n} decode as 0011 activate, 0101 read, 0100 write, 0010 precharge, 0001 auto refresh, 0000 mode set, 0110 burst stop, 0111 no-op. An accepted command raises only its own strobe (act_o, rd_o, wr_o, pre_o, ref_o, mrs_o, stop_o) for the one cycle after the sampling edge. At most one strobe or err_o is high at a time.
- R2: An activate to an idle bank takes addr[11] as the bank and addr[10:0] as the row. It drives them on bank_o and row_o, sets that bank's bit in open_o and stores the row in open_row_o (bank 0 in bits 10:0, bank 1 in bits 21:11).
- R3: A read or write to an open bank drives addr[11] on bank_o, addr[7:0] on col_o and addr[10] on ap_o.
- R4: byte_en_o is the inverse of dqm (bit 0 the lower byte) captured with an accepted read or write, and is zero in every other cycle.
- R5: A precharge with addr[10] low closes only the bank named by addr[11]. With addr[10] high it closes both banks. pre_mask_o shows the banks closed (bit n for bank n).
- R6: A read or write with addr[10] high closes its bank at the BL-th valid edge after the edge that took the command. BL comes from mode bits [2:0]: 0 gives 1, 1 gives 2, 2 gives 4, 3 gives 8, 7 gives 256, and any other value gives 1.
- R7: A mode set command stores all 12 address bits, bank bit included, and shows them on mode_o.
- R8: With cs_n high no strobe is raised and neither the mode word nor the bank rows change.
- R9: An edge that follows a cycle with cke low is ignored entirely: no strobe, and no change to bank state or to the mode word.
- R10: An activate to an open bank, or a read or write to an idle bank, raises err_o for one cycle with no other strobe. Bank state and byte enables stay unchanged.
- R11: Synchronous active-high reset leaves both banks idle, all strobes low, mode_o at zero and the clock treated as enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| cke | input | 1 | Clock enable for the following edge |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| addr | input | 12 | Row, column, bank, flags or mode word |
| dqm | input | 2 | Byte masks, high blocks a byte |
| act_o | output | 1 | Activate accepted |
| rd_o | output | 1 | Read accepted |
| wr_o | output | 1 | Write accepted |
| pre_o | output | 1 | Precharge accepted |
| ref_o | output | 1 | Auto refresh accepted |
| mrs_o | output | 1 | Mode set accepted |
| stop_o | output | 1 | Burst stop accepted |
| err_o | output | 1 | Illegal command for the bank state |
| bank_o | output | 1 | Bank of the last activate, read or write |
| row_o | output | 11 | Row of the last activate |
| col_o | output | 8 | Column of the last read or write |
| ap_o | output | 1 | Auto-precharge flag of the last read or write |
| pre_mask_o | output | 2 | Banks closed by a precharge command |
| byte_en_o | output | 2 | Active byte lanes of the current read or write |
| mode_o | output | 12 | Stored mode word |
| open_o | output | 2 | Per-bank open flag |
| open_row_o | output | 22 | Open row per bank |

## Verification
The bench builds the block with its default parameters: a 12-bit address, 11-bit rows, 8-bit columns and one bank bit. These give the two-bank geometry and a full-page burst counter of 256. The bench programs burst lengths of four and one so that the auto-precharge close is observed on the exact edge in both a multi-cycle and a single-cycle case. The single-bank and all-bank precharge paths and the error cases are all reached through the ports.

// File: rtl/sdram_cmd_pkg.sv
package sdram_cmd_pkg;
    typedef enum logic [2:0] {
        CMD_NOP,
        CMD_ACT,
        CMD_RD,
        CMD_WR,
        CMD_PRE,
        CMD_REF,
        CMD_MRS,
        CMD_STOP
    } cmd_e;
endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
    import sdram_cmd_pkg::*;
(
    input  logic valid,
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output cmd_e cmd
);
    always_comb begin
        if (!valid || cs_n) begin
            cmd = CMD_NOP;
        end else begin
            unique case ({ras_n, cas_n, we_n})
                3'b011:  cmd = CMD_ACT;
                3'b101:  cmd = CMD_RD;
                3'b100:  cmd = CMD_WR;
                3'b010:  cmd = CMD_PRE;
                3'b001:  cmd = CMD_REF;
                3'b000:  cmd = CMD_MRS;
                3'b110:  cmd = CMD_STOP;
                default: cmd = CMD_NOP;
            endcase
        end
    end
endmodule

// File: rtl/sdram_bank_track.sv
module sdram_bank_track #(
    parameter int NBANK  = 2,
    parameter int BANK_W = 1,
    parameter int ROW_W  = 11
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     act_en,
    input  logic [BANK_W-1:0]        act_bank,
    input  logic [ROW_W-1:0]         act_row,
    input  logic [NBANK-1:0]         close_mask,
    output logic [NBANK-1:0]         open_o,
    output logic [NBANK*ROW_W-1:0]   rows_o
);
    typedef struct packed {
        logic [NBANK-1:0]            open;
        logic [NBANK-1:0][ROW_W-1:0] row;
    } trk_t;

    trk_t trk_d, trk_q;

    always_comb begin
        trk_d = trk_q;
        for (int b = 0; b < NBANK; b++) begin
            if (close_mask[b]) begin
                trk_d.open[b] = 1'b0;
            end
            if (act_en && act_bank == BANK_W'(b)) begin
                trk_d.open[b] = 1'b1;
                trk_d.row[b]  = act_row;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            trk_q <= '0;
        end else begin
            trk_q <= trk_d;
        end
    end

    assign open_o = trk_q.open;

    for (genvar g = 0; g < NBANK; g++) begin : g_row
        assign rows_o[g*ROW_W +: ROW_W] = trk_q.row[g];
    end

    // R2
    bank_open_chk: assert property (@(posedge clk) disable iff (rst)
        act_en |=> open_o[$past(act_bank)]);
endmodule

// File: rtl/sdram_burst_timer.sv
module sdram_burst_timer #(
    parameter int NBANK  = 2,
    parameter int BANK_W = 1,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              start,
    input  logic              start_ap,
    input  logic [BANK_W-1:0] start_bank,
    input  logic [CNT_W-1:0]  load_cnt,
    output logic [NBANK-1:0]  close_mask_o
);
    typedef struct packed {
        logic              pend;
        logic [BANK_W-1:0] bank;
        logic [CNT_W-1:0]  cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;
    logic fire;

    assign fire = tick && tmr_q.pend && (tmr_q.cnt == '0);

    always_comb begin
        tmr_d = tmr_q;
        if (tick && tmr_q.pend) begin
            if (tmr_q.cnt == '0) begin
                tmr_d.pend = 1'b0;
            end else begin
                tmr_d.cnt = tmr_q.cnt - 1'b1;
            end
        end
        if (tick && start) begin
            tmr_d.pend = start_ap;
            tmr_d.bank = start_bank;
            tmr_d.cnt  = load_cnt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    always_comb begin
        for (int b = 0; b < NBANK; b++) begin
            close_mask_o[b] = fire && (tmr_q.bank == BANK_W'(b));
        end
    end

    // R6
    ap_arm_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && start && start_ap) |=> tmr_q.pend);
endmodule

// File: rtl/sdram_cmd_front.sv
module sdram_cmd_front
    import sdram_cmd_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int ROW_W  = 11,
    parameter int COL_W  = 8,
    parameter int BANK_W = 1,
    parameter int AP_BIT = 10,
    parameter int MASK_W = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cke,
    input  logic                    cs_n,
    input  logic                    ras_n,
    input  logic                    cas_n,
    input  logic                    we_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [MASK_W-1:0]       dqm,
    output logic                    act_o,
    output logic                    rd_o,
    output logic                    wr_o,
    output logic                    pre_o,
    output logic                    ref_o,
    output logic                    mrs_o,
    output logic                    stop_o,
    output logic                    err_o,
    output logic [BANK_W-1:0]       bank_o,
    output logic [ROW_W-1:0]        row_o,
    output logic [COL_W-1:0]        col_o,
    output logic                    ap_o,
    output logic [(1<<BANK_W)-1:0]  pre_mask_o,
    output logic [MASK_W-1:0]       byte_en_o,
    output logic [ADDR_W-1:0]       mode_o,
    output logic [(1<<BANK_W)-1:0]  open_o,
    output logic [(1<<BANK_W)*ROW_W-1:0] open_row_o
);
    localparam int NBANK = 1 << BANK_W;

    typedef struct packed {
        logic              cke_en;
        logic              act;
        logic              rd;
        logic              wr;
        logic              pre;
        logic              refr;
        logic              mrs;
        logic              stop;
        logic              err;
        logic [BANK_W-1:0] bank;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
        logic              ap;
        logic [NBANK-1:0]  pre_mask;
        logic [MASK_W-1:0] byte_en;
        logic [ADDR_W-1:0] mode;
    } front_t;

    front_t            st_d, st_q;
    cmd_e              cmd;
    logic [BANK_W-1:0] sel_bank;
    logic              sel_open;
    logic [NBANK-1:0]  open_vec;
    logic [NBANK-1:0]  tmr_close;
    logic [NBANK-1:0]  close_mask;
    logic [COL_W-1:0]  burst_cnt;

    sdram_cmd_decode u_decode (
        .valid (st_q.cke_en),
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .cmd   (cmd)
    );

    assign sel_bank = addr[ADDR_W-1 -: BANK_W];
    assign sel_open = open_vec[sel_bank];

    // burst length minus one, from the stored mode word
    always_comb begin
        unique case (st_q.mode[2:0])
            3'd1:    burst_cnt = COL_W'(1);
            3'd2:    burst_cnt = COL_W'(3);
            3'd3:    burst_cnt = COL_W'(7);
            3'd7:    burst_cnt = '1;
            default: burst_cnt = '0;
        endcase
    end

    always_comb begin
        st_d          = st_q;
        st_d.cke_en   = cke;
        st_d.act      = 1'b0;
        st_d.rd       = 1'b0;
        st_d.wr       = 1'b0;
        st_d.pre      = 1'b0;
        st_d.refr     = 1'b0;
        st_d.mrs      = 1'b0;
        st_d.stop     = 1'b0;
        st_d.err      = 1'b0;
        st_d.pre_mask = '0;
        st_d.byte_en  = '0;
        unique case (cmd)
            CMD_ACT: begin
                if (sel_open) begin
                    st_d.err = 1'b1;
                end else begin
                    st_d.act  = 1'b1;
                    st_d.bank = sel_bank;
                    st_d.row  = addr[ROW_W-1:0];
                end
            end
            CMD_RD, CMD_WR: begin
                if (!sel_open) begin
                    st_d.err = 1'b1;
                end else begin
                    st_d.rd      = (cmd == CMD_RD);
                    st_d.wr      = (cmd == CMD_WR);
                    st_d.bank    = sel_bank;
                    st_d.col     = addr[COL_W-1:0];
                    st_d.ap      = addr[AP_BIT];
                    st_d.byte_en = ~dqm;
                end
            end
            CMD_PRE: begin
                st_d.pre = 1'b1;
                for (int b = 0; b < NBANK; b++) begin
                    st_d.pre_mask[b] = addr[AP_BIT] || (sel_bank == BANK_W'(b));
                end
            end
            CMD_REF:  st_d.refr = 1'b1;
            CMD_MRS: begin
                st_d.mrs  = 1'b1;
                st_d.mode = addr;
            end
            CMD_STOP: st_d.stop = 1'b1;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q        <= '0;
            st_q.cke_en <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign close_mask = st_d.pre_mask | tmr_close;

    sdram_burst_timer #(
        .NBANK  (NBANK),
        .BANK_W (BANK_W),
        .CNT_W  (COL_W)
    ) u_timer (
        .clk          (clk),
        .rst          (rst),
        .tick         (st_q.cke_en),
        .start        (st_d.rd || st_d.wr),
        .start_ap     (addr[AP_BIT]),
        .start_bank   (sel_bank),
        .load_cnt     (burst_cnt),
        .close_mask_o (tmr_close)
    );

    sdram_bank_track #(
        .NBANK  (NBANK),
        .BANK_W (BANK_W),
        .ROW_W  (ROW_W)
    ) u_track (
        .clk        (clk),
        .rst        (rst),
        .act_en     (st_d.act),
        .act_bank   (sel_bank),
        .act_row    (addr[ROW_W-1:0]),
        .close_mask (close_mask),
        .open_o     (open_vec),
        .rows_o     (open_row_o)
    );

    assign act_o      = st_q.act;
    assign rd_o       = st_q.rd;
    assign wr_o       = st_q.wr;
    assign pre_o      = st_q.pre;
    assign ref_o      = st_q.refr;
    assign mrs_o      = st_q.mrs;
    assign stop_o     = st_q.stop;
    assign err_o      = st_q.err;
    assign bank_o     = st_q.bank;
    assign row_o      = st_q.row;
    assign col_o      = st_q.col;
    assign ap_o       = st_q.ap;
    assign pre_mask_o = st_q.pre_mask;
    assign byte_en_o  = st_q.byte_en;
    assign mode_o     = st_q.mode;
    assign open_o     = open_vec;

    // R1
    strobe_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({act_o, rd_o, wr_o, pre_o, ref_o, mrs_o, stop_o, err_o}));

    // R9
    cke_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !st_q.cke_en |=> !(act_o || rd_o || wr_o || pre_o || ref_o || mrs_o || stop_o || err_o));

    // R8
    desel_hold_chk: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> !(act_o || rd_o || wr_o || pre_o || ref_o || mrs_o || stop_o || err_o)
                 && $stable(mode_o) && $stable(open_row_o));

    // R10
    idle_access_chk: assert property (@(posedge clk) disable iff (rst)
        ((cmd == CMD_RD || cmd == CMD_WR) && !sel_open) |=> err_o && !rd_o && !wr_o && byte_en_o == '0);

    // R10
    busy_act_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_ACT && sel_open) |=> err_o && !act_o && $stable(open_row_o));

    // R5
    pre_all_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_PRE && addr[AP_BIT]) |=> open_o == '0);
endmodule

// File: tb/sdram_cmd_front_tb.sv
`timescale 1ns/1ps
module sdram_cmd_front_tb_top;
    localparam logic [3:0] C_ACT  = 4'b0011;
    localparam logic [3:0] C_RD   = 4'b0101;
    localparam logic [3:0] C_WR   = 4'b0100;
    localparam logic [3:0] C_PRE  = 4'b0010;
    localparam logic [3:0] C_REF  = 4'b0001;
    localparam logic [3:0] C_MRS  = 4'b0000;
    localparam logic [3:0] C_STOP = 4'b0110;
    localparam logic [3:0] C_NOP  = 4'b0111;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cke = 1'b1;
    logic        cs_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [11:0] addr = '0;
    logic [1:0]  dqm = '0;
    logic act_o, rd_o, wr_o, pre_o, ref_o, mrs_o, stop_o, err_o;
    logic [0:0]  bank_o;
    logic [10:0] row_o;
    logic [7:0]  col_o;
    logic        ap_o;
    logic [1:0]  pre_mask_o, byte_en_o, open_o;
    logic [11:0] mode_o;
    logic [21:0] open_row_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    sdram_cmd_front dut_i (
        .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .addr(addr), .dqm(dqm),
        .act_o(act_o), .rd_o(rd_o), .wr_o(wr_o), .pre_o(pre_o),
        .ref_o(ref_o), .mrs_o(mrs_o), .stop_o(stop_o), .err_o(err_o),
        .bank_o(bank_o), .row_o(row_o), .col_o(col_o), .ap_o(ap_o),
        .pre_mask_o(pre_mask_o), .byte_en_o(byte_en_o), .mode_o(mode_o),
        .open_o(open_o), .open_row_o(open_row_o)
    );

    function automatic logic [7:0] strb();
        return {act_o, rd_o, wr_o, pre_o, ref_o, mrs_o, stop_o, err_o};
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic [3:0] c, input logic [11:0] a, input logic [1:0] m);
        @(negedge clk);
        {cs_n, ras_n, cas_n, we_n} = c;
        addr = a;
        dqm  = m;
        @(posedge clk);
        #1;
        {cs_n, ras_n, cas_n, we_n} = C_NOP;
        addr = '0;
        dqm  = '0;
    endtask

    task automatic t_reset();
        chk("R11", "open after reset", 32'(open_o), 0);
        chk("R11", "mode after reset", 32'(mode_o), 0);
        chk("R11", "strobes after reset", 32'(strb()), 0);
    endtask

    task automatic t_activate();
        drive(C_ACT, 12'h123, 2'b00);
        chk("R1", "activate strobe", 32'(strb()), 32'h80);
        chk("R2", "bank0 row", 32'(row_o), 32'h123);
        chk("R2", "bank0 index", 32'(bank_o), 0);
        drive(C_ACT, 12'hFFF, 2'b00);
        chk("R2", "bank1 index", 32'(bank_o), 1);
        chk("R2", "both open", 32'(open_o), 32'h3);
        chk("R2", "stored rows", 32'(open_row_o), {10'd0, 11'h7FF, 11'h123});
    endtask

    task automatic t_errors();
        drive(C_ACT, 12'h055, 2'b00);
        chk("R10", "act to open bank", 32'(strb()), 32'h01);
        chk("R10", "row kept", 32'(open_row_o[10:0]), 32'h123);
        drive(C_PRE, 12'h800, 2'b00);
        chk("R5", "single precharge strobe", 32'(strb()), 32'h10);
        chk("R5", "single precharge mask", 32'(pre_mask_o), 32'h2);
        chk("R5", "bank1 closed", 32'(open_o), 32'h1);
        drive(C_RD, 12'h812, 2'b00);
        chk("R10", "read idle bank", 32'(strb()), 32'h01);
        chk("R10", "no byte enable on error", 32'(byte_en_o), 0);
        chk("R10", "state after error", 32'(open_o), 32'h1);
    endtask

    task automatic t_rdwr();
        drive(C_RD, 12'h05A, 2'b01);
        chk("R1", "read strobe", 32'(strb()), 32'h40);
        chk("R3", "read column", 32'(col_o), 32'h5A);
        chk("R3", "read no autopre", 32'(ap_o), 0);
        chk("R4", "read upper lane only", 32'(byte_en_o), 32'h2);
        drive(C_WR, 12'h0A5, 2'b00);
        chk("R1", "write strobe", 32'(strb()), 32'h20);
        chk("R3", "write column", 32'(col_o), 32'hA5);
        chk("R4", "write both lanes", 32'(byte_en_o), 32'h3);
        drive(C_NOP, 12'h0FF, 2'b00);
        chk("R1", "nop strobes", 32'(strb()), 0);
        chk("R4", "lanes clear on nop", 32'(byte_en_o), 0);
    endtask

    task automatic t_misc();
        drive(C_REF, 12'h000, 2'b00);
        chk("R1", "refresh strobe", 32'(strb()), 32'h08);
        drive(C_STOP, 12'h000, 2'b00);
        chk("R1", "burst stop strobe", 32'(strb()), 32'h02);
        drive(C_MRS, 12'h822, 2'b00);
        chk("R1", "mode set strobe", 32'(strb()), 32'h04);
        chk("R7", "mode word", 32'(mode_o), 32'h822);
    endtask

    task automatic t_autopre();
        // mode bits [2:0] = 2 gives a burst of four
        drive(C_ACT, 12'h855, 2'b00);
        chk("R2", "bank1 reopened", 32'(open_o), 32'h3);
        drive(C_RD, 12'hC10, 2'b00);
        chk("R3", "autopre flag", 32'(ap_o), 1);
        chk("R3", "autopre bank", 32'(bank_o), 1);
        chk("R6", "open at burst start", 32'(open_o), 32'h3);
        for (int i = 1; i < 4; i++) begin
            drive(C_NOP, 12'h000, 2'b00);
            chk("R6", "still open mid burst", 32'(open_o), 32'h3);
        end
        drive(C_NOP, 12'h000, 2'b00);
        chk("R6", "closed after four", 32'(open_o), 32'h1);
        drive(C_MRS, 12'h000, 2'b00);
        chk("R7", "mode cleared", 32'(mode_o), 0);
        drive(C_WR, 12'h433, 2'b10);
        chk("R6", "open on write edge", 32'(open_o), 32'h1);
        chk("R4", "write lower lane", 32'(byte_en_o), 32'h1);
        drive(C_NOP, 12'h000, 2'b00);
        chk("R6", "closed after one", 32'(open_o), 0);
    endtask

    task automatic t_pre_all();
        drive(C_ACT, 12'h0AA, 2'b00);
        drive(C_ACT, 12'h8BB, 2'b00);
        chk("R2", "both open again", 32'(open_o), 32'h3);
        drive(C_PRE, 12'h400, 2'b00);
        chk("R5", "all precharge mask", 32'(pre_mask_o), 32'h3);
        chk("R5", "all closed", 32'(open_o), 0);
    endtask

    task automatic t_deselect();
        drive(4'b1011, 12'h012, 2'b00);
        chk("R8", "deselected activate strobes", 32'(strb()), 0);
        chk("R8", "deselected activate state", 32'(open_o), 0);
        drive(4'b1000, 12'h777, 2'b00);
        chk("R8", "deselected mode set", 32'(mode_o), 0);
    endtask

    task automatic t_cke();
        @(negedge clk);
        cke = 1'b0;
        @(posedge clk);
        drive(C_ACT, 12'h001, 2'b00);
        chk("R9", "gated strobes", 32'(strb()), 0);
        chk("R9", "gated state", 32'(open_o), 0);
        @(negedge clk);
        cke = 1'b1;
        @(posedge clk);
        drive(C_ACT, 12'h001, 2'b00);
        chk("R9", "enabled again", 32'(strb()), 32'h80);
        chk("R9", "bank0 open", 32'(open_o), 32'h1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_activate();
        t_errors();
        t_rdwr();
        t_misc();
        t_autopre();
        t_pre_all();
        t_deselect();
        t_cke();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog all requirements actual=timeout expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule